// File: doc/BRIEF.md
# Ticket-Based Fair Lock Manager

This block arbitrates one shared resource among a fixed set of requesters and grants it strictly first-come-first-served. Two counters do the work. A dispenser counter hands out numbered tickets. A serving counter names the ticket that currently owns the resource. A requester pulses its acquire line and is given the next ticket number, which its own slot stores. The requester holds the lock while the serving counter equals its stored ticket, and it gives the lock up with a release pulse. The release moves the serving counter on by one, so the next ticket in line is granted.

A waiting slot only compares its stored number against the serving count. It never retries an atomic update, so waiting costs no extra activity. When several requesters ask in the same cycle, the lowest index gets the lowest number. Both counters wrap modulo 2^TW. TW must be large enough that all N_REQ outstanding tickets are distinct.

Top module: `tkt_fair_lock`

## Requirements
- R1: After reset no grant is asserted, `serve_o` is 0, every ticket output is 0, and the first ticket issued is 0.
- R2: An acquire pulse from a requester that holds no ticket is accepted. That requester's field of `ticket_o` (bits i*TW upward) shows the issued number from the cycle after the pulse until the requester releases. The field reads 0 while the requester holds no ticket.
- R3: When several requesters are accepted in the same cycle, they receive consecutive numbers in ascending index order, starting from the next unissued number.
- R4: `grant_o[i]` is high exactly while requester i holds a ticket equal to `serve_o`. At most one grant is high at any time.
- R5: A release pulse from the grant holder increments `serve_o` at the next edge. In that same cycle the holder's grant drops, its ticket field returns to 0, and the holder of the next ticket is granted.
- R6: A release pulse from a requester that does not hold the grant is ignored. `serve_o`, all grants and all ticket fields are unchanged by it.
- R7: An acquire pulse from a requester that already holds a ticket (waiting or granted) is ignored, and its stored ticket is unchanged. This includes the cycle in which it releases.
- R8: Both counters wrap modulo 2^TW. The grant order equals the issue order across the wrap.
- R9: A granted requester keeps its grant on every cycle until it pulses release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | Per-requester lock grant |
| ticket_o | output | N_REQ*TW | Issued ticket of each requester, field i at bits i*TW; 0 when none is held |
| serve_o | output | TW | Now-serving counter value |

## Verification
An accepted acquire shows its ticket one clock after the pulse. If that ticket equals the serving count, the grant appears in the same cycle. A release from the holder moves `serve_o`, drops that grant and raises the next one, all one clock after the pulse. Inputs are driven at the falling edge and held across a single rising edge. Every output is then compared one nanosecond after that rising edge against a requirement-level model. A scoreboard queue holds requester indices in issue order, and a monitor pops the queue on each rising grant, so the order is checked as grants appear.

// File: rtl/tkt_fair_lock_pkg.sv
package tkt_fair_lock_pkg;

   // Per-requester slot state
   typedef enum logic {
      SLOT_IDLE = 1'b0,
      SLOT_HOLD = 1'b1
   } slot_st_e;

endpackage

// File: rtl/tkt_dispenser.sv
// Next-ticket counter with same-cycle prefix allocation (fetch-and-add).
module tkt_dispenser #(
   parameter int N_REQ = 4,
   parameter int TW    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_REQ-1:0]      take_i,
   output logic [N_REQ*TW-1:0]   offer_o
);

   logic [TW-1:0] next_q;
   logic [TW-1:0] run;

   always_comb begin
      run     = '0;
      offer_o = '0;
      for (int i = 0; i < N_REQ; i++) begin
         offer_o[i*TW +: TW] = next_q + run;
         run = run + TW'(take_i[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) next_q <= '0;
      else        next_q <= next_q + run;
   end

endmodule

// File: rtl/tkt_server.sv
// Now-serving counter: advances on a release by the current holder.
module tkt_server #(
   parameter int N_REQ = 4,
   parameter int TW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  drop_i,
   output logic [TW-1:0]     serve_o
);

   logic step;
   assign step = |drop_i;

   always_ff @(posedge clk) begin
      if (!rst_n)    serve_o <= '0;
      else if (step) serve_o <= serve_o + TW'(1);
   end

endmodule

// File: rtl/tkt_slot.sv
// One requester's ticket register and grant compare.
module tkt_slot
   import tkt_fair_lock_pkg::*;
#(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acq_i,
   input  logic          rel_i,
   input  logic [TW-1:0] offer_i,
   input  logic [TW-1:0] serve_i,
   output logic          take_o,
   output logic          drop_o,
   output logic          grant_o,
   output logic [TW-1:0] ticket_o
);

   slot_st_e      st_q;
   logic [TW-1:0] tkt_q;

   assign take_o   = acq_i && (st_q == SLOT_IDLE);
   assign grant_o  = (st_q == SLOT_HOLD) && (tkt_q == serve_i);
   assign drop_o   = grant_o && rel_i;
   assign ticket_o = (st_q == SLOT_HOLD) ? tkt_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SLOT_IDLE;
         tkt_q <= '0;
      end else if (take_o) begin
         st_q  <= SLOT_HOLD;
         tkt_q <= offer_i;
      end else if (drop_o) begin
         st_q  <= SLOT_IDLE;
      end
   end

endmodule

// File: rtl/tkt_fair_lock.sv
module tkt_fair_lock #(
   parameter int N_REQ = 4,
   parameter int TW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_REQ-1:0]    acq_i,
   input  logic [N_REQ-1:0]    rel_i,
   output logic [N_REQ-1:0]    grant_o,
   output logic [N_REQ*TW-1:0] ticket_o,
   output logic [TW-1:0]       serve_o
);

   localparam int TKT_SPACE = 1 << TW;

   generate
      if (N_REQ < 1)         begin : g_bad_n  $error("N_REQ must be at least 1"); end
      if (TW < 1 || TW > 16) begin : g_bad_tw $error("TW out of range");        end
      if (TKT_SPACE < N_REQ) begin : g_bad_sp $error("2**TW must cover N_REQ"); end
   endgenerate

   logic [N_REQ-1:0]    take;
   logic [N_REQ-1:0]    drop;
   logic [N_REQ*TW-1:0] offer;

   tkt_dispenser #(.N_REQ(N_REQ), .TW(TW)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .offer_o (offer)
   );

   tkt_server #(.N_REQ(N_REQ), .TW(TW)) u_serve (
      .clk     (clk),
      .rst_n   (rst_n),
      .drop_i  (drop),
      .serve_o (serve_o)
   );

   generate
      for (genvar g = 0; g < N_REQ; g++) begin : g_slot
         tkt_slot #(.TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .acq_i    (acq_i[g]),
            .rel_i    (rel_i[g]),
            .offer_i  (offer[g*TW +: TW]),
            .serve_i  (serve_o),
            .take_o   (take[g]),
            .drop_o   (drop[g]),
            .grant_o  (grant_o[g]),
            .ticket_o (ticket_o[g*TW +: TW])
         );
      end
   endgenerate

endmodule

// File: rtl/tkt_fair_lock_chk.sv
module tkt_fair_lock_chk #(
   parameter int N_REQ = 4,
   parameter int TW    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_REQ-1:0]    acq_i,
   input logic [N_REQ-1:0]    rel_i,
   input logic [N_REQ-1:0]    grant_o,
   input logic [N_REQ*TW-1:0] ticket_o,
   input logic [TW-1:0]       serve_o
);

   p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   p_serve_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant_o & rel_i)) |=> (serve_o == TW'($past(serve_o) + 1)));

   p_stray_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(grant_o & rel_i)) |=> $stable(serve_o));

   generate
      for (genvar g = 0; g < N_REQ; g++) begin : g_req
         p_grant_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[g] && !rel_i[g]) |=> grant_o[g]);

         p_ticket_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[g] && !rel_i[g]) |=> $stable(ticket_o[g*TW +: TW]));
      end
   endgenerate

endmodule

bind tkt_fair_lock tkt_fair_lock_chk #(.N_REQ(N_REQ), .TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acq_i    (acq_i),
   .rel_i    (rel_i),
   .grant_o  (grant_o),
   .ticket_o (ticket_o),
   .serve_o  (serve_o)
);

// File: tb/sim_tkt_fair_lock.sv
`timescale 1ns/1ps
module sim_tkt_fair_lock;

   localparam int N  = 4;
   localparam int TW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    acq_i = '0;
   logic [N-1:0]    rel_i = '0;
   logic [N-1:0]    grant_o;
   logic [N*TW-1:0] ticket_o;
   logic [TW-1:0]   serve_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // requirement-level model
   logic [TW-1:0] m_next, m_serve;
   logic [N-1:0]  m_busy;
   logic [TW-1:0] m_tkt [N];
   int            sb_q[$];
   logic [N-1:0]  prev_g;

   always #2 clk = ~clk;   // 250 MHz

   tkt_fair_lock #(.N_REQ(N), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
      .grant_o(grant_o), .ticket_o(ticket_o), .serve_o(serve_o)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int tk(input int i);
      return int'(ticket_o[i*TW +: TW]);
   endfunction

   // model step for one cycle of inputs
   task automatic model(input logic [N-1:0] a, input logic [N-1:0] r);
      logic [N-1:0] old_busy;
      old_busy = m_busy;
      for (int i = 0; i < N; i++)
         if (old_busy[i] && m_tkt[i] == m_serve && r[i]) begin
            m_busy[i] = 1'b0;
            m_serve   = m_serve + 1'b1;
         end
      for (int i = 0; i < N; i++)
         if (!old_busy[i] && a[i]) begin
            m_busy[i] = 1'b1;
            m_tkt[i]  = m_next;
            m_next    = m_next + 1'b1;
            sb_q.push_back(i);
         end
   endtask

   task automatic compare_all();
      for (int i = 0; i < N; i++) begin
         check("R2", tk(i), m_busy[i] ? int'(m_tkt[i]) : 0, $sformatf("ticket[%0d]", i));
         check("R4", int'(grant_o[i]), int'(m_busy[i] && m_tkt[i] == m_serve),
               $sformatf("grant[%0d]", i));
      end
      check("R5", int'(serve_o), int'(m_serve), "serve");
   endtask

   task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] r);
      @(negedge clk);
      acq_i = a; rel_i = r;
      model(a, r);
      @(posedge clk);
      #1;
      acq_i = '0; rel_i = '0;
      compare_all();
   endtask

   function automatic logic [N-1:0] holder();
      for (int i = 0; i < N; i++)
         if (m_busy[i] && m_tkt[i] == m_serve) return N'(1) << i;
      return '0;
   endfunction

   // scoreboard monitor: grants must rise in issue order (R8 order, R3)
   always @(negedge clk) begin
      if (!rst_n) prev_g <= '0;
      else begin
         for (int i = 0; i < N; i++)
            if (grant_o[i] && !prev_g[i]) begin
               n_chk++;
               if (sb_q.size() == 0) begin
                  n_fail++;
                  $display("FAIL R8 grant order: actual %0d expected none", i);
               end else begin
                  int e;
                  e = sb_q.pop_front();
                  if (e != i) begin
                     n_fail++;
                     $display("FAIL R8 grant order: actual %0d expected %0d", i, e);
                  end
               end
            end
         prev_g <= grant_o;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_next = '0; m_serve = '0; m_busy = '0;
      for (int i = 0; i < N; i++) m_tkt[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1", int'(grant_o), 0, "grants after reset");
      check("R1", int'(serve_o), 0, "serve after reset");
      check("R1", int'(ticket_o), 0, "tickets after reset");

      // R2 single acquire, lock free -> granted next cycle
      cyc(4'b0100, 4'b0000);
      check("R1", tk(2), 0, "first issued ticket");
      check("R2", int'(grant_o), 4'b0100, "grant after lone acquire");

      // R3 simultaneous acquires, lowest index first
      cyc(4'b1011, 4'b0000);
      check("R3", tk(0), 1, "req0 ticket");
      check("R3", tk(1), 2, "req1 ticket");
      check("R3", tk(3), 3, "req3 ticket");

      // R7 re-acquire by holders ignored
      cyc(4'b0101, 4'b0000);
      check("R7", tk(2), 0, "granted re-acquire");
      check("R7", tk(0), 1, "waiting re-acquire");

      // R6 stray release
      cyc(4'b0000, 4'b0010);
      check("R6", int'(serve_o), 0, "serve after stray release");
      check("R6", int'(grant_o), 4'b0100, "grant after stray release");
      check("R6", tk(1), 2, "ticket after stray release");

      // R5 valid release, with R7 acquire in the release cycle
      cyc(4'b0100, 4'b0100);
      check("R5", int'(serve_o), 1, "serve after release");
      check("R5", int'(grant_o), 4'b0001, "next holder granted");
      check("R7", tk(2), 0, "acquire in release cycle ignored");

      // R9 grant holds while idle
      repeat (5) cyc(4'b0000, 4'b0000);
      check("R9", int'(grant_o), 4'b0001, "grant held");

      cyc(4'b0000, 4'b0001);
      cyc(4'b0000, 4'b0010);
      check("R5", int'(grant_o), 4'b1000, "req3 granted");
      cyc(4'b0000, 4'b1000);
      check("R5", int'(grant_o), 0, "no grant when queue empty");
      check("R5", int'(serve_o), 4, "serve at 4");

      // R8 wrap: rounds of full contention
      for (int rnd = 0; rnd < 3; rnd++) begin
         cyc(4'b1111, 4'b0000);
         if (rnd == 1) begin
            check("R8", tk(0), 0, "wrapped ticket req0");
            check("R8", tk(3), 3, "wrapped ticket req3");
         end
         for (int k = 0; k < N; k++) cyc(4'b0000, holder());
      end
      // arrival order differs from index order
      cyc(4'b1000, 4'b0000);
      cyc(4'b0010, 4'b0000);
      cyc(4'b0001, 4'b0000);
      check("R4", int'(grant_o), 4'b1000, "first arrival granted");
      for (int k = 0; k < 3; k++) cyc(4'b0000, holder());
      check("R8", int'(serve_o), int'(m_serve), "serve after wrap");
      check("R8", sb_q.size(), 0, "scoreboard drained");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule